// File: doc/BRIEF.md
# Leveled Set/Clear Interrupt Controller

This block gathers level-sensitive device requests for four processor interrupt levels, numbered 3 to 6, with up to four devices on each level. Each level owns an enable mask and a status view. Software reaches both through a small byte-wide register bus. An enable write carries a mode bit in bit 7. When bit 7 is one, every device whose bit is one in bits 3:0 is switched on. When bit 7 is zero, every such device is switched off. Because of this, software never needs a read-modify-write to change one source.

Each level drives its own interrupt line, which is active while any enabled device on that level is requesting. A 3-bit priority output carries the number of the highest level whose line is active, and zero when none is. The status register shows the requesting devices after masking by the enable bits. Read data is registered and holds until the next read.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Reset clears every enable bit. After reset, all enable reads return 0x00, all interrupt lines are low and the priority output is 0, even while every device request is high.
- R2: A write to a level's enable register with bit 7 = 1 sets the enable bit of each device whose bit in 3:0 is one. Bits 6:4 are ignored and all other enable bits keep their value.
- R3: A write to a level's enable register with bit 7 = 0 clears the enable bit of each device whose bit in 3:0 is one. All other enable bits keep their value.
- R4: An enable read returns the level's mask in bits 3:0, with bits 7:4 reading zero.
- R5: A status read returns the level's device requests ANDed with its enable mask in bits 3:0, with bits 7:4 reading zero.
- R6: irq_o bit k (k = 0 for level 3, up to k = 3 for level 6) is the OR of level k's enabled requests. It follows the request inputs and enable state with no added register stage.
- R7: prio_o equals 3 + k for the highest k with irq_o[k] high, or 0 when irq_o is all zero.
- R8: Reads of unmapped offsets return 0x00. Writes to status registers or to unmapped offsets change no enable bit.
- R9: Read data appears on rdata_o at the clock edge that samples the read strobe, so it is valid one cycle after the strobe. It holds its value until the next read, and writes do not change it.
- R10: Level L (3 to 6) has its status register at offset 0x100 + 0x10·L and its enable register at offset 0x104 + 0x10·L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Register byte offset |
| req_wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| dev_req_i | input | 16 | Device requests, level k in bits 4k+3:4k |
| irq_o | output | 4 | Per-level interrupt lines, bit 0 = level 3 |
| prio_o | output | 3 | Highest active level number, or 0 |

## Verification
Requests are held high on every line through reset and after it. This shows that masking alone keeps the lines quiet, which a design that passed requests straight through would not do. Enable writes use set-only, clear-only and mixed-bit patterns, including a set write with bits 6:4 also set. Each pattern is followed by a read, so an overwrite or a missed clear shows up as a wrong mask. Asymmetric request patterns across all four levels, combined with partial masks, separate a correct AND from swapped levels or swapped device bits in the status reads. Lines are then dropped one at a time, top level first, so that each priority value is seen in turn.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int NUM_LVL   = 4;
  localparam int DEVS      = 4;
  localparam int FIRST_LVL = 3;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 8;
  localparam int PRIO_W    = 3;
  localparam logic [3:0] PAGE_SEL = 4'h1;
  localparam logic [3:0] STAT_OFF = 4'h0;
  localparam logic [3:0] EN_OFF   = 4'h4;
endpackage

// File: rtl/lvl_irq_decode.sv
module lvl_irq_decode
  import lvl_irq_pkg::*;
#(
  parameter int A_W    = ADDR_W,
  parameter int N_LVL  = NUM_LVL,
  parameter int LVL0   = FIRST_LVL,
  localparam int IDX_W = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
  input  logic [A_W-1:0]   addr_i,
  output logic             hit_stat_o,
  output logic             hit_en_o,
  output logic [IDX_W-1:0] idx_o
);
  logic       page_hit;
  logic [4:0] slot;
  logic       slot_hit;

  assign page_hit = (addr_i[A_W-1:8] == (A_W-8)'(PAGE_SEL));
  assign slot     = {1'b0, addr_i[7:4]};
  assign slot_hit = (slot >= 5'(LVL0)) && (slot < 5'(LVL0 + N_LVL));
  assign idx_o    = IDX_W'(addr_i[7:4] - 4'(LVL0));

  assign hit_stat_o = page_hit && slot_hit && (addr_i[3:0] == STAT_OFF);
  assign hit_en_o   = page_hit && slot_hit && (addr_i[3:0] == EN_OFF);
endmodule

// File: rtl/lvl_irq_level.sv
module lvl_irq_level
  import lvl_irq_pkg::*;
#(
  parameter int N_DEV = DEVS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             set_i,
  input  logic [N_DEV-1:0] mask_i,
  input  logic [N_DEV-1:0] req_i,
  output logic [N_DEV-1:0] en_o,
  output logic [N_DEV-1:0] pend_o,
  output logic             irq_o
);
  logic [N_DEV-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (wr_i) begin
      if (set_i) en_q <= en_q | mask_i;
      else       en_q <= en_q & ~mask_i;
    end
  end

  assign en_o   = en_q;
  assign pend_o = req_i & en_q;
  assign irq_o  = |pend_o;
endmodule

// File: rtl/lvl_irq_prio.sv
module lvl_irq_prio
  import lvl_irq_pkg::*;
#(
  parameter int N_LVL = NUM_LVL,
  parameter int LVL0  = FIRST_LVL,
  parameter int P_W   = PRIO_W
) (
  input  logic [N_LVL-1:0] irq_i,
  output logic [P_W-1:0]   prio_o
);
  // upward scan: last hit is the highest level
  always_comb begin
    prio_o = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (irq_i[i]) prio_o = P_W'(LVL0 + i);
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int N_LVL  = NUM_LVL,
  parameter int N_DEV  = DEVS,
  parameter int LVL0   = FIRST_LVL,
  parameter int A_W    = ADDR_W,
  parameter int D_W    = DATA_W,
  parameter int P_W    = PRIO_W,
  localparam int IDX_W = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic                   req_write_i,
  input  logic [A_W-1:0]         req_addr_i,
  input  logic [D_W-1:0]         req_wdata_i,
  output logic [D_W-1:0]         rdata_o,
  input  logic [N_LVL*N_DEV-1:0] dev_req_i,
  output logic [N_LVL-1:0]       irq_o,
  output logic [P_W-1:0]         prio_o
);
  logic             hit_stat;
  logic             hit_en;
  logic [IDX_W-1:0] idx;
  logic [N_DEV-1:0] en_a   [N_LVL];
  logic [N_DEV-1:0] pend_a [N_LVL];
  logic [D_W-1:0]   rd_word;
  logic [D_W-1:0]   rdata_q;
  logic             wr_go;
  logic             rd_go;
  logic             unused_wbits;

  assign wr_go        = req_valid_i && req_write_i;
  assign rd_go        = req_valid_i && !req_write_i;
  assign unused_wbits = ^req_wdata_i[D_W-2:N_DEV];

  lvl_irq_decode #(
    .A_W  (A_W),
    .N_LVL(N_LVL),
    .LVL0 (LVL0)
  ) u_dec (
    .addr_i    (req_addr_i),
    .hit_stat_o(hit_stat),
    .hit_en_o  (hit_en),
    .idx_o     (idx)
  );

  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    logic wr_here;
    assign wr_here = wr_go && hit_en && (idx == IDX_W'(g));

    lvl_irq_level #(
      .N_DEV(N_DEV)
    ) u_lvl (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_i  (wr_here),
      .set_i (req_wdata_i[D_W-1]),
      .mask_i(req_wdata_i[N_DEV-1:0]),
      .req_i (dev_req_i[g*N_DEV +: N_DEV]),
      .en_o  (en_a[g]),
      .pend_o(pend_a[g]),
      .irq_o (irq_o[g])
    );
  end

  lvl_irq_prio #(
    .N_LVL(N_LVL),
    .LVL0 (LVL0),
    .P_W  (P_W)
  ) u_prio (
    .irq_i (irq_o),
    .prio_o(prio_o)
  );

  always_comb begin
    rd_word = '0;
    if (hit_stat)    rd_word = {{(D_W-N_DEV){1'b0}}, pend_a[idx]};
    else if (hit_en) rd_word = {{(D_W-N_DEV){1'b0}}, en_a[idx]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_go) rdata_q <= rd_word;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk
  import lvl_irq_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_valid_i,
  input logic                     req_write_i,
  input logic [ADDR_W-1:0]        req_addr_i,
  input logic [DATA_W-1:0]        req_wdata_i,
  input logic [DATA_W-1:0]        rdata_o,
  input logic [NUM_LVL*DEVS-1:0]  dev_req_i,
  input logic [NUM_LVL-1:0]       irq_o,
  input logic [PRIO_W-1:0]        prio_o
);
  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o == '0) |-> (prio_o == '0));

  a_r7_top_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[NUM_LVL-1] |-> (prio_o == PRIO_W'(FIRST_LVL + NUM_LVL - 1)));

  a_r6_no_req_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_req_i == '0) |-> (irq_o == '0));

  a_r3_clear_all_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_addr_i == ADDR_W'(12'h134) &&
     req_wdata_i == DATA_W'(8'h0F)) |=> !irq_o[0]);

  a_r8_off_page_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_addr_i[ADDR_W-1:8] != (ADDR_W-8)'(PAGE_SEL))
    |=> (rdata_o == '0));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> $stable(rdata_o));
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .req_wdata_i(req_wdata_i),
  .rdata_o    (rdata_o),
  .dev_req_i  (dev_req_i),
  .irq_o      (irq_o),
  .prio_o     (prio_o)
);

// File: tb/lvl_irq_ctrl_test.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_test;
  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] dev_req = '0;
  logic [3:0]  irq;
  logic [2:0]  prio;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];
  logic [3:0] en_m [4];

  always #2.5 clk = ~clk;

  lvl_irq_ctrl uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_valid_i(valid),
    .req_write_i(write),
    .req_addr_i (addr),
    .req_wdata_i(wdata),
    .rdata_o    (rdata),
    .dev_req_i  (dev_req),
    .irq_o      (irq),
    .prio_o     (prio)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_irq();
    logic [3:0] r;
    for (int l = 0; l < 4; l++) r[l] = |(dev_req[l*4 +: 4] & en_m[l]);
    return r;
  endfunction

  function automatic logic [2:0] exp_prio();
    logic [3:0] v;
    logic [2:0] p;
    v = exp_irq();
    p = 3'd0;
    for (int l = 0; l < 4; l++) if (v[l]) p = 3'(3 + l);
    return p;
  endfunction

  // driver: one write, model updated from the requirements
  task automatic wr(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
    if (a[11:8] == 4'h1 && a[3:0] == 4'h4 && a[7:4] >= 4'd3 && a[7:4] <= 4'd6) begin
      if (d[7]) en_m[a[7:4]-4'd3] = en_m[a[7:4]-4'd3] | d[3:0];
      else      en_m[a[7:4]-4'd3] = en_m[a[7:4]-4'd3] & ~d[3:0];
    end
  endtask

  // driver: one read, expected value pushed to the scoreboard
  task automatic rd(logic [11:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = a;
    sb_q.push_back('{val: e, tag: tag});
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic chk_out(string tag);
    check({tag, " irq"}, {4'h0, irq}, {4'h0, exp_irq()});
    check({tag, " prio"}, {5'h0, prio}, {5'h0, exp_prio()});
  endtask

  function automatic logic [7:0] stat_exp(int l);
    return {4'h0, dev_req[l*4 +: 4] & en_m[l]};
  endfunction

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (valid && !write) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          check("R9 unexpected read", rdata, 8'hxx);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(e.tag, rdata, e.val);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 4; l++) en_m[l] = 4'h0;
    dev_req = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", rdata, 8'h00);
    chk_out("R1 masked after reset");
    for (int l = 3; l <= 6; l++) rd(12'(12'h104 + 12'h10 * l), 8'h00, "R1 enable cleared");
    for (int l = 3; l <= 6; l++) rd(12'(12'h100 + 12'h10 * l), 8'h00, "R5 status masked");

    wr(12'h134, 8'h81);
    rd(12'h134, 8'h01, "R2 set level3 dev0");
    chk_out("R6 level3 only");

    wr(12'h144, 8'h86);
    rd(12'h144, 8'h06, "R2 set level4 dev1,2");
    wr(12'h144, 8'h02);
    rd(12'h144, 8'h04, "R3 clear level4 dev1");
    rd(12'h134, 8'h01, "R3 other level untouched");
    chk_out("R7 level4 highest");

    wr(12'h164, 8'hF8);
    rd(12'h164, 8'h08, "R4 upper bits ignored and read zero");
    chk_out("R7 level6 highest");

    @(negedge clk);
    dev_req = 16'h7FFF;
    @(negedge clk);
    chk_out("R7 level6 request dropped");

    wr(12'h154, 8'h8F);
    @(negedge clk);
    dev_req = 16'h5A3C;
    @(negedge clk);
    for (int l = 0; l < 4; l++) rd(12'(12'h130 + 12'h10 * l), stat_exp(l), "R5 status pattern A");
    chk_out("R6 pattern A");
    @(negedge clk);
    dev_req = 16'hA5C3;
    @(negedge clk);
    for (int l = 0; l < 4; l++) rd(12'(12'h130 + 12'h10 * l), stat_exp(l), "R5 status pattern B");
    chk_out("R6 pattern B");

    wr(12'h150, 8'h0F);
    wr(12'h140, 8'h8F);
    wr(12'h174, 8'h8F);
    wr(12'h124, 8'h8F);
    wr(12'h034, 8'h00);
    wr(12'h138, 8'h8F);
    rd(12'h134, {4'h0, en_m[0]}, "R8 ignored writes lvl3");
    rd(12'h144, {4'h0, en_m[1]}, "R8 ignored writes lvl4");
    rd(12'h154, {4'h0, en_m[2]}, "R8 ignored writes lvl5");
    rd(12'h164, {4'h0, en_m[3]}, "R8 ignored writes lvl6");
    rd(12'h138, 8'h00, "R8 unmapped 138");
    rd(12'h170, 8'h00, "R8 unmapped 170");
    rd(12'h124, 8'h00, "R8 unmapped 124");
    rd(12'h234, 8'h00, "R8 unmapped 234");
    rd(12'h034, 8'h00, "R10 wrong page");

    @(negedge clk);
    dev_req = 16'hFFFF;
    wr(12'h164, 8'h0F);
    chk_out("R7 level5 after level6 off");
    wr(12'h154, 8'h0F);
    chk_out("R7 level4 after level5 off");
    wr(12'h144, 8'h0F);
    chk_out("R7 level3 after level4 off");
    wr(12'h134, 8'h0F);
    chk_out("R3 all cleared prio zero");

    rd(12'h134, 8'h00, "R3 level3 cleared");
    wr(12'h154, 8'h85);
    rd(12'h154, 8'h05, "R10 level5 enable offset");
    // latency: old value before the edge, new after
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = 12'h150;
    sb_q.push_back('{val: 8'h05, tag: "R9 new data after edge"});
    #1;
    check("R9 old data before edge", rdata, 8'h05);
    @(negedge clk);
    valid = 1'b0;
    wr(12'h150, 8'h00);
    wr(12'h134, 8'h8F);
    repeat (3) @(negedge clk);
    check("R9 held through writes", rdata, 8'h05);
    wr(12'h154, 8'h05);
    rd(12'h150, 8'h00, "R5 status after disable");

    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", 8'(sb_q.size()), 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule